// File: doc/BRIEF.md
# Wiper Tap Switch Controller

This block drives the switch array of a 128-tap resistor ladder. It takes a 7-bit wiper code and two shutdown controls. It produces one enable per tap switch, an enable for the switch that joins the ladder to its high terminal, and an enable for a switch that shorts the wiper to the low terminal. Code 0 closes the switch nearest the low terminal and code 127 the switch nearest the high terminal. The wiper-to-low resistance therefore grows monotonically with the code.

Tap changes are sequenced make-before-break, so the wiper never floats. When the code changes, the new tap switch is closed for one clock cycle while the old switch is still closed. The old switch opens on the following cycle. A settled flag tells the surrounding logic whether such a move is still under way.

Shutdown is requested by a low level on either an external pin or a register bit. During shutdown the ladder is isolated from its high end, all tap switches are opened and the wiper is tied to the low end. The applied code is kept, so leaving shutdown brings back the tap that matches the wiper code at once.

Top module: `wiper_tap_sequencer`

## Requirements
- R1: When running and settled, exactly tap enable `tap_en[n]` is high, where n is the unsigned value of `code_i`. Bit 0 is the tap nearest the low terminal and bit 127 the tap nearest the high terminal.
- R2: When running and `code_i` changes from a settled value a to a new value b, the tap enables behave as follows. In the cycle after the clock edge that samples b, both `tap_en[a]` and `tap_en[b]` are high and `settled` is low. After the next edge only `tap_en[b]` is high and `settled` is high.
- R3: At most two tap enables are ever high together. Once the block has left reset, a tap enable only falls after a cycle in which two enables were high (make-before-break).
- R4: Whenever the block is running and `settled` is high, exactly one tap enable is high.
- R5: Shutdown is active when `shdn_pin_n` is 0 or `shdn_bit` is 0, and running only when both are 1. In shutdown, `tap_en` is all zero, `hi_en` is 0 and `short_en` is 1. When running, `hi_en` is 1 and `short_en` is 0. These outputs follow the two controls in the same cycle.
- R6: Shutdown does not disturb the code. On leaving shutdown, the tap for the present `code_i` is enabled in the same cycle, with no overlap cycle and with `settled` high. If `code_i` was unchanged, this is the tap held before shutdown.
- R7: A code change that arrives during an overlap cycle waits until that overlap cycle completes. The cycle after the overlap shows only the intermediate tap with `settled` low. A fresh overlap to the latest code then follows.
- R8: While `rst_n` is low, only `tap_en[0]` is high (when running) and `settled` is low. On the first clock edge after reset, the tap for `code_i` is enabled directly, with no overlap cycle, and `settled` is high.
- R9: Presenting the same code again causes no overlap cycle: the enabled tap is unchanged and `settled` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_i | input | 7 | Requested wiper code |
| shdn_pin_n | input | 1 | Shutdown pin, low requests shutdown |
| shdn_bit | input | 1 | Shutdown control bit, low requests shutdown |
| tap_en | output | 128 | One enable per tap switch, bit n for code n |
| hi_en | output | 1 | Enable for the high-terminal switch |
| short_en | output | 1 | Enable for the wiper-to-low short |
| settled | output | 1 | High when no tap move is in progress |

## Verification
The bench sweeps every code, both in ascending steps and in large strided jumps. It checks for the one overlap cycle holding exactly the old and new taps. A design that opened the old tap first would show a single enable in that cycle. A design that lingered would show two enables a cycle too long.

The bench also covers three corner cases:
- Mid-overlap code changes: a controller that dropped or hurried the second change would skip the intermediate tap.
- All four pin/bit combinations: a design that ORed the controls instead of ANDing them would leave the ladder connected.
- Shutdown exit and the first cycle after reset: a design that lost the held code or sequenced from a stale tap would show the wrong tap or a spurious overlap.

// File: rtl/wiper_tap_sequencer.sv
module wiper_tap_sequencer #(
  parameter int CODE_W = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CODE_W-1:0]        code_i,
  input  logic                     shdn_pin_n,
  input  logic                     shdn_bit,
  output logic [(1<<CODE_W)-1:0]   tap_en,
  output logic                     hi_en,
  output logic                     short_en,
  output logic                     settled
);
  localparam int TAPS = 1 << CODE_W;

  logic              run;
  logic [CODE_W-1:0] cur_q, old_q;
  logic              ovl_q, primed_q;

  assign run = shdn_pin_n & shdn_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q    <= '0;
      old_q    <= '0;
      ovl_q    <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      primed_q <= 1'b1;
      ovl_q    <= 1'b0;
      if (!primed_q || !run) begin
        cur_q <= code_i;
      end else if (!ovl_q && code_i != cur_q) begin
        old_q <= cur_q;
        cur_q <= code_i;
        ovl_q <= 1'b1;
      end
    end
  end

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign tap_en[i] = run & ((cur_q == CODE_W'(i)) | (ovl_q & (old_q == CODE_W'(i))));
  end

  assign hi_en    = run;
  assign short_en = ~run;
  assign settled  = primed_q & ~ovl_q & (cur_q == code_i);
endmodule

module wiper_tap_sequencer_chk #(
  parameter int CODE_W = 7
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [CODE_W-1:0]      code_i,
  input logic                   shdn_pin_n,
  input logic                   shdn_bit,
  input logic [(1<<CODE_W)-1:0] tap_en,
  input logic                   hi_en,
  input logic                   short_en,
  input logic                   settled,
  input logic                   primed_q
);
  localparam int TAPS = 1 << CODE_W;
  logic run;
  assign run = shdn_pin_n & shdn_bit;

  p_shdn_outputs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (short_en && !hi_en && tap_en == '0));

  p_run_outputs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (hi_en && !short_en));

  p_at_most_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_en) <= 2);

  p_make_before_break_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $past(primed_q) && (($past(tap_en) & ~tap_en) != '0))
      |-> $countones($past(tap_en)) == 2);

  p_single_when_settled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && settled) |-> $countones(tap_en) == 1);

  p_overlap_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_en) == 2 |=> $countones(tap_en) <= 1);

  p_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !$past(run) && $stable(code_i) && $past(primed_q))
      |-> tap_en == (TAPS'(1) << code_i));
endmodule

bind wiper_tap_sequencer wiper_tap_sequencer_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .code_i(code_i), .shdn_pin_n(shdn_pin_n),
  .shdn_bit(shdn_bit), .tap_en(tap_en), .hi_en(hi_en), .short_en(short_en),
  .settled(settled), .primed_q(primed_q)
);

// File: tb/wiper_tap_sequencer_bench.sv
`timescale 1ns/1ps
module wiper_tap_sequencer_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [6:0]   code_i;
  logic         shdn_pin_n, shdn_bit;
  logic [127:0] tap_en;
  logic         hi_en, short_en, settled;
  int checks = 0;
  int failures = 0;
  int prev;

  always #2 clk = ~clk;

  wiper_tap_sequencer u_wiper_tap_sequencer (
    .clk(clk), .rst_n(rst_n), .code_i(code_i), .shdn_pin_n(shdn_pin_n),
    .shdn_bit(shdn_bit), .tap_en(tap_en), .hi_en(hi_en), .short_en(short_en),
    .settled(settled)
  );

  function automatic logic [127:0] oh(int n);
    return 128'd1 << n;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_tap(input string req, input logic [127:0] exp, input logic exp_settled);
    chk(tap_en == exp, req, tap_en, exp);
    chk(settled == exp_settled, {req, " settled"}, 128'(settled), 128'(exp_settled));
  endtask

  task automatic move(input int n, input string req);
    code_i = 7'(n);
    tick();
    if (n != prev) begin
      chk_tap({req, " R2 overlap"}, oh(n) | oh(prev), 1'b0);
      chk($countones(tap_en) <= 2, "R3 count", 128'($countones(tap_en)), 128'd2);
      tick();
    end
    chk_tap({req, " R1 settled tap"}, oh(n), 1'b1);
    prev = n;
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; shdn_pin_n = 1'b1; shdn_bit = 1'b1; code_i = 7'd37;
    repeat (3) tick();
    chk_tap("R8 in reset", oh(0), 1'b0);
    rst_n = 1'b1;
    tick();
    chk_tap("R8 first cycle no overlap", oh(37), 1'b1);
    prev = 37;

    for (int i = 0; i < 128; i++) move(i, "ascending");
    for (int i = 0; i < 128; i++) move((i * 53 + 11) % 128, "strided");
    move(127, "top");
    move(0, "bottom");

    code_i = 7'(prev);
    tick();
    chk_tap("R9 same code", oh(prev), 1'b1);
    tick();
    chk_tap("R9 same code hold", oh(prev), 1'b1);

    move(40, "pre-R7");
    code_i = 7'd10;
    tick();
    chk_tap("R7 first overlap", oh(40) | oh(10), 1'b0);
    code_i = 7'd100;
    tick();
    chk_tap("R7 deferred intermediate", oh(10), 1'b0);
    tick();
    chk_tap("R7 second overlap", oh(10) | oh(100), 1'b0);
    tick();
    chk_tap("R7 final", oh(100), 1'b1);
    prev = 100;

    for (int c = 0; c < 4; c++) begin
      shdn_pin_n = c[0]; shdn_bit = c[1];
      #1;
      if (c == 3) begin
        chk(hi_en == 1'b1 && short_en == 1'b0, "R5 running hi/short", {hi_en, short_en}, 128'b10);
        chk(tap_en == oh(100), "R5 running tap", tap_en, oh(100));
      end else begin
        chk(hi_en == 1'b0 && short_en == 1'b1, "R5 shutdown hi/short", {hi_en, short_en}, 128'b01);
        chk(tap_en == '0, "R5 shutdown taps open", tap_en, '0);
      end
      tick();
    end

    move(77, "pre-R6");
    shdn_pin_n = 1'b0;
    repeat (3) tick();
    chk(tap_en == '0, "R5 pin shutdown", tap_en, '0);
    shdn_pin_n = 1'b1;
    #1;
    chk_tap("R6 restore held tap", oh(77), 1'b1);
    tick();
    chk_tap("R6 restore no overlap", oh(77), 1'b1);

    shdn_bit = 1'b0;
    tick();
    code_i = 7'd20;
    tick();
    tick();
    chk(short_en == 1'b1, "R5 bit shutdown", 128'(short_en), 128'd1);
    shdn_bit = 1'b1;
    #1;
    chk_tap("R6 restore new code", oh(20), 1'b1);
    tick();
    chk_tap("R6 no overlap after exit", oh(20), 1'b1);
    prev = 20;
    move(21, "post-R6");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule